// File: doc/BRIEF.md
# Parallel RGB Panel Raster Timing Generator

This block produces the scan timing for a parallel RGB display panel. A free-running divider turns the system clock into a pixel enable and a pixel clock output. Two phase counters, one for pixels within a line and one for lines within a frame, walk through sync, back porch, active and front porch phases. From them the block drives a line sync, a frame sync, a data-enable strobe and the position of the current active pixel. Every length comes from a configuration input held stable while scanning.

A scan-enable input starts the scan on the next pixel boundary. When it is cleared the frame in progress still runs to its end. Scanning then stops and a sticky frame-done flag is raised. Software clears that flag by writing 1 to a clear input. An end-of-frame pulse marks the end of every frame. A separate AC-bias output toggles after a programmable number of lines. A counter of those toggles raises a one-cycle interrupt pulse.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel period is D clocks, where D is the divisor input, and a divisor of 0 or 1 counts as 2. The pixel clock output is high for floor(D/2) clocks of each pixel period, and low for the rest.
- R2: Each line is made of hsync_w+1 sync pixels, then hbp_cfg+1 back porch pixels, then 16*(ppl_cfg+1) active pixels, then hfp_cfg+1 front porch pixels. Line sync is active during the sync pixels.
- R3: Each frame is made of vsync_w+1 sync lines, then vbp_cfg+1 back porch lines, then lpp_cfg+1 active lines, then vfp_cfg+1 front porch lines. Frame sync is active during all clocks of the sync lines.
- R4: data_en is high only in active pixels of active lines. While it is high, pix_x and pix_y give the pixel and line index within the active area, counted from 0.
- R5: When inv_pclk, inv_lsync or inv_fsync is 1, the matching output is inverted, so the sync outputs become active-low with an idle level of 1. When the bit is 0 the output is active-high with an idle level of 0.
- R6: With sync_sel=1 and sync_fall=1, the sync outputs change on the clock where the pixel clock falls, which is half a pixel later. Otherwise they change on the clock where the pixel clock rises.
- R7: eof is a one-clock pulse that starts one clock after the last pixel of the last front porch line. While scanning stays enabled, frames repeat back to back with a period of D*H*V clocks.
- R8: When scan_en is cleared, the current frame completes. Scanning then stops: data_en stays 0, the syncs stay at their idle level and eof stays 0. frame_done is set together with that frame's eof. It stays set until done_clr=1 is applied.
- R9: ac_bias toggles at the end of every (acb_period+1)-th line. acb_irq pulses for one clock on every acb_toggles-th toggle. A value of acb_toggles=0 disables the pulse.
- R10: After reset, data_en, eof, frame_done, ac_bias and acb_irq are 0, and the syncs sit at their idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Start (1) or stop at frame end (0) |
| div_cfg | input | DIV_W | Pixel clock divisor |
| ppl_cfg | input | PPL_W | Active width in 16-pixel units, minus one |
| lpp_cfg | input | LPP_W | Active lines minus one |
| hsync_w | input | SYNC_W | Line sync width minus one, in pixels |
| hbp_cfg | input | PORCH_W | Horizontal back porch minus one |
| hfp_cfg | input | PORCH_W | Horizontal front porch minus one |
| vsync_w | input | SYNC_W | Frame sync width minus one, in lines |
| vbp_cfg | input | PORCH_W | Vertical back porch minus one |
| vfp_cfg | input | PORCH_W | Vertical front porch minus one |
| inv_pclk | input | 1 | Invert pixel clock output |
| inv_lsync | input | 1 | Invert line sync |
| inv_fsync | input | 1 | Invert frame sync |
| sync_sel | input | 1 | Enable selectable sync edge |
| sync_fall | input | 1 | Sync outputs follow the falling pixel clock edge |
| acb_period | input | ACP_W | Lines per AC-bias toggle, minus one |
| acb_toggles | input | ACT_W | Toggles per AC-bias interrupt, 0 disables it |
| done_clr | input | 1 | Write-1 clear of frame_done |
| pclk | output | 1 | Pixel clock |
| line_sync | output | 1 | Line sync |
| frame_sync | output | 1 | Frame sync |
| data_en | output | 1 | Active pixel strobe |
| pix_x | output | XW | Active pixel index |
| pix_y | output | YW | Active line index |
| ac_bias | output | 1 | AC-bias output |
| acb_irq | output | 1 | AC-bias toggle-count pulse |
| eof | output | 1 | End-of-frame pulse |
| frame_done | output | 1 | Sticky stop-complete flag |

## Verification
The bench builds the block with its default widths: a 7-bit width field, an 11-bit line field and an 8-bit divisor. This keeps the wide position counters of the larger variant in play. Small field values are chosen so that a full frame fits in a few hundred clocks. Every clock of whole frames can then be counted against closed-form sums. Divisors 0, 1, 3 and 5 reach the minimum-divisor clamp and the odd split of the pixel clock high time. AC-bias periods that divide the frame length give an exact toggle and interrupt count per frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // order of phases inside a line and inside a frame
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_t;
endpackage

// File: rtl/rtg_pixclk.sv
module rtg_pixclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             inv_pclk,
  output logic             pix_en,
  output logic             fall_tick,
  output logic             pclk
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] div_eff, half, cnt, cnt_nxt;
  logic             pclk_raw;

  always_comb begin
    div_eff   = (div_cfg < MIN_DIV) ? MIN_DIV : div_cfg;
    half      = div_eff >> 1;
    pix_en    = (cnt >= div_eff - 1'b1);
    cnt_nxt   = pix_en ? '0 : cnt + 1'b1;
    fall_tick = (cnt_nxt == half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      pclk_raw <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      pclk_raw <= (cnt_nxt < half);
    end
  end

  assign pclk = pclk_raw ^ inv_pclk;

  // R1
  pix_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> !pix_en);
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] len_sync,
  input  logic [CNT_W-1:0] len_back,
  input  logic [CNT_W-1:0] len_act,
  input  logic [CNT_W-1:0] len_front,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cur_last;
  logic             at_last;

  always_comb begin
    case (phase)
      PH_SYNC:  cur_last = len_sync;
      PH_BACK:  cur_last = len_back;
      PH_ACT:   cur_last = len_act;
      default:  cur_last = len_front;
    endcase
    at_last = (cnt >= cur_last);
    wrap    = step && at_last && (phase == PH_FRONT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (at_last) begin
        cnt   <= '0;
        phase <= phase_t'(phase + 2'd1);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  axis_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase == PH_SYNC) && (cnt == '0));
endmodule

// File: rtl/rtg_acbias.sv
module rtg_acbias #(
  parameter int P_W = 8,
  parameter int T_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_tick,
  input  logic [P_W-1:0] period,
  input  logic [T_W-1:0] toggles,
  output logic           ac_bias,
  output logic           irq
);
  logic [P_W-1:0] line_cnt;
  logic [T_W-1:0] tog_cnt;
  logic           flip;

  assign flip = line_tick && (line_cnt >= period);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
      tog_cnt  <= '0;
      ac_bias  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (line_tick) line_cnt <= flip ? '0 : line_cnt + 1'b1;
      if (flip) begin
        ac_bias <= ~ac_bias;
        if (toggles != '0) begin
          if (tog_cnt >= toggles - 1'b1) begin
            tog_cnt <= '0;
            irq     <= 1'b1;
          end else begin
            tog_cnt <= tog_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R9
  acb_irq_on_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ac_bias != $past(ac_bias)));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int PPL_W   = 7,
  parameter int LPP_W   = 11,
  parameter int PORCH_W = 8,
  parameter int SYNC_W  = 6,
  parameter int DIV_W   = 8,
  parameter int ACP_W   = 8,
  parameter int ACT_W   = 4,
  localparam int XW = (PPL_W + 4 > PORCH_W) ? PPL_W + 4 : PORCH_W,
  localparam int YW = (LPP_W > PORCH_W) ? LPP_W : PORCH_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scan_en,
  input  logic [DIV_W-1:0]   div_cfg,
  input  logic [PPL_W-1:0]   ppl_cfg,
  input  logic [LPP_W-1:0]   lpp_cfg,
  input  logic [SYNC_W-1:0]  hsync_w,
  input  logic [PORCH_W-1:0] hbp_cfg,
  input  logic [PORCH_W-1:0] hfp_cfg,
  input  logic [SYNC_W-1:0]  vsync_w,
  input  logic [PORCH_W-1:0] vbp_cfg,
  input  logic [PORCH_W-1:0] vfp_cfg,
  input  logic               inv_pclk,
  input  logic               inv_lsync,
  input  logic               inv_fsync,
  input  logic               sync_sel,
  input  logic               sync_fall,
  input  logic [ACP_W-1:0]   acb_period,
  input  logic [ACT_W-1:0]   acb_toggles,
  input  logic               done_clr,
  output logic               pclk,
  output logic               line_sync,
  output logic               frame_sync,
  output logic               data_en,
  output logic [XW-1:0]      pix_x,
  output logic [YW-1:0]      pix_y,
  output logic               ac_bias,
  output logic               acb_irq,
  output logic               eof,
  output logic               frame_done
);
  logic    pix_en, fall_tick;
  logic    running;
  logic    h_step, h_wrap, v_wrap;
  phase_t  h_phase, v_phase;
  logic [XW-1:0] h_cnt;
  logic [YW-1:0] v_cnt;
  logic [XW-1:0] act_last_x;
  logic    ls_raw, fs_raw, ls_hold, fs_hold, fall_mode;

  rtg_pixclk #(.DIV_W(DIV_W)) u_pixclk (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .inv_pclk(inv_pclk),
    .pix_en(pix_en), .fall_tick(fall_tick), .pclk(pclk)
  );

  assign h_step     = running & pix_en;
  assign act_last_x = XW'({ppl_cfg, 4'hF});

  rtg_axis #(.CNT_W(XW)) u_haxis (
    .clk(clk), .rst(rst), .step(h_step),
    .len_sync(XW'(hsync_w)), .len_back(XW'(hbp_cfg)),
    .len_act(act_last_x), .len_front(XW'(hfp_cfg)),
    .phase(h_phase), .cnt(h_cnt), .wrap(h_wrap)
  );

  rtg_axis #(.CNT_W(YW)) u_vaxis (
    .clk(clk), .rst(rst), .step(h_wrap),
    .len_sync(YW'(vsync_w)), .len_back(YW'(vbp_cfg)),
    .len_act(YW'(lpp_cfg)), .len_front(YW'(vfp_cfg)),
    .phase(v_phase), .cnt(v_cnt), .wrap(v_wrap)
  );

  rtg_acbias #(.P_W(ACP_W), .T_W(ACT_W)) u_acbias (
    .clk(clk), .rst(rst), .line_tick(h_wrap),
    .period(acb_period), .toggles(acb_toggles),
    .ac_bias(ac_bias), .irq(acb_irq)
  );

  // run control, end of frame and sticky done flag
  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      eof        <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      eof <= v_wrap;
      if (!running) begin
        if (scan_en && pix_en) running <= 1'b1;
      end else if (v_wrap && !scan_en) begin
        running <= 1'b0;
      end
      if (v_wrap && !scan_en) frame_done <= 1'b1;
      else if (done_clr)      frame_done <= 1'b0;
    end
  end

  // half-pixel delayed copies for falling-edge sync mode
  always_ff @(posedge clk) begin
    if (rst) begin
      ls_hold <= 1'b0;
      fs_hold <= 1'b0;
    end else if (fall_tick) begin
      ls_hold <= ls_raw;
      fs_hold <= fs_raw;
    end
  end

  always_comb begin
    ls_raw     = running && (h_phase == PH_SYNC);
    fs_raw     = running && (v_phase == PH_SYNC);
    fall_mode  = sync_sel && sync_fall;
    line_sync  = (fall_mode ? ls_hold : ls_raw) ^ inv_lsync;
    frame_sync = (fall_mode ? fs_hold : fs_raw) ^ inv_fsync;
    data_en    = running && (h_phase == PH_ACT) && (v_phase == PH_ACT);
    pix_x      = data_en ? h_cnt : '0;
    pix_y      = data_en ? v_cnt : '0;
  end

  // R7
  eof_single_chk: assert property (@(posedge clk) disable iff (rst)
    eof |=> !eof);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !done_clr) |=> frame_done);

  // R8
  done_with_eof_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done) |-> eof);

  // R4
  de_bound_chk: assert property (@(posedge clk) disable iff (rst)
    data_en |-> (pix_x <= act_last_x) && (pix_y <= YW'(lpp_cfg)));
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  localparam int PPL_W = 7, LPP_W = 11, PORCH_W = 8, SYNC_W = 6;
  localparam int DIV_W = 8, ACP_W = 8, ACT_W = 4;
  localparam int XW = 11, YW = 11;
  localparam int NV = 5;
  // div ppl lpp hsw hbp hfp vsw vbp vfp ipclk ils ifs acp acn exp_frame
  localparam int TAB [NV][15] = '{
    '{2, 0, 3, 1, 2, 1, 0, 1, 0, 0, 0, 0, 1, 2, 368},
    '{0, 1, 1, 0, 0, 0, 1, 0, 2, 1, 1, 1, 3, 0, 560},
    '{3, 0, 0, 3, 0, 4, 0, 0, 0, 0, 0, 0, 0, 1, 312},
    '{1, 2, 2, 2, 1, 0, 0, 0, 1, 0, 1, 0, 6, 1, 756},
    '{5, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0, 475}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, scan_en, inv_pclk, inv_lsync, inv_fsync, sync_sel, sync_fall, done_clr;
  logic [DIV_W-1:0]   div_cfg;
  logic [PPL_W-1:0]   ppl_cfg;
  logic [LPP_W-1:0]   lpp_cfg;
  logic [SYNC_W-1:0]  hsync_w, vsync_w;
  logic [PORCH_W-1:0] hbp_cfg, hfp_cfg, vbp_cfg, vfp_cfg;
  logic [ACP_W-1:0]   acb_period;
  logic [ACT_W-1:0]   acb_toggles;
  logic pclk, line_sync, frame_sync, data_en, ac_bias, acb_irq, eof, frame_done;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst), .scan_en(scan_en), .div_cfg(div_cfg),
    .ppl_cfg(ppl_cfg), .lpp_cfg(lpp_cfg), .hsync_w(hsync_w),
    .hbp_cfg(hbp_cfg), .hfp_cfg(hfp_cfg), .vsync_w(vsync_w),
    .vbp_cfg(vbp_cfg), .vfp_cfg(vfp_cfg), .inv_pclk(inv_pclk),
    .inv_lsync(inv_lsync), .inv_fsync(inv_fsync), .sync_sel(sync_sel),
    .sync_fall(sync_fall), .acb_period(acb_period), .acb_toggles(acb_toggles),
    .done_clr(done_clr), .pclk(pclk), .line_sync(line_sync),
    .frame_sync(frame_sync), .data_en(data_en), .pix_x(pix_x), .pix_y(pix_y),
    .ac_bias(ac_bias), .acb_irq(acb_irq), .eof(eof), .frame_done(frame_done)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // frame window measurement results
  int m_clk, m_ls, m_fs, m_de, m_pc, m_maxx, m_maxy, m_fx, m_fy, m_tog, m_irq;

  task automatic measure_frame();
    logic prev_ac;
    bit   first;
    do @(negedge clk); while (eof !== 1'b1);
    m_clk = 0; m_ls = 0; m_fs = 0; m_de = 0; m_pc = 0;
    m_maxx = 0; m_maxy = 0; m_fx = -1; m_fy = -1; m_tog = 0; m_irq = 0;
    prev_ac = ac_bias;
    first = 1'b1;
    do begin
      @(negedge clk);
      m_clk++;
      if (line_sync != inv_lsync) m_ls++;
      if (frame_sync != inv_fsync) m_fs++;
      if (pclk) m_pc++;
      if (acb_irq) m_irq++;
      if (ac_bias != prev_ac) m_tog++;
      prev_ac = ac_bias;
      if (data_en) begin
        m_de++;
        if (first) begin m_fx = int'(pix_x); m_fy = int'(pix_y); first = 1'b0; end
        if (int'(pix_x) > m_maxx) m_maxx = int'(pix_x);
        if (int'(pix_y) > m_maxy) m_maxy = int'(pix_y);
      end
    end while (eof !== 1'b1);
  endtask

  task automatic load_vec(input int i);
    div_cfg     = DIV_W'(TAB[i][0]);
    ppl_cfg     = PPL_W'(TAB[i][1]);
    lpp_cfg     = LPP_W'(TAB[i][2]);
    hsync_w     = SYNC_W'(TAB[i][3]);
    hbp_cfg     = PORCH_W'(TAB[i][4]);
    hfp_cfg     = PORCH_W'(TAB[i][5]);
    vsync_w     = SYNC_W'(TAB[i][6]);
    vbp_cfg     = PORCH_W'(TAB[i][7]);
    vfp_cfg     = PORCH_W'(TAB[i][8]);
    inv_pclk    = TAB[i][9][0];
    inv_lsync   = TAB[i][10][0];
    inv_fsync   = TAB[i][11][0];
    acb_period  = ACP_W'(TAB[i][12]);
    acb_toggles = ACT_W'(TAB[i][13]);
    sync_sel    = 1'b0;
    sync_fall   = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    scan_en = 1'b0;
    done_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // wait for an active edge of line_sync, report pclk before and at it
  task automatic wait_ls_rise(output logic pc_prev, output logic pc_now);
    logic ls_prev, pc_last;
    ls_prev = line_sync;
    pc_last = pclk;
    forever begin
      @(negedge clk);
      if ((line_sync != inv_lsync) && (ls_prev == inv_lsync)) begin
        pc_prev = pc_last;
        pc_now  = pclk;
        break;
      end
      ls_prev = line_sync;
      pc_last = pclk;
    end
  endtask

  initial begin
    int d, h, v, hf, de_cnt, eof_cnt, ls_bad;
    logic pp, pn;

    // ---- reset state, inverted line sync idle level
    load_vec(0);
    inv_lsync = 1'b1;
    do_reset();
    @(negedge clk);
    chk("R10", "data_en after reset", int'(data_en), 0);
    chk("R10", "eof after reset", int'(eof), 0);
    chk("R10", "frame_done after reset", int'(frame_done), 0);
    chk("R10", "ac_bias after reset", int'(ac_bias), 0);
    chk("R10", "acb_irq after reset", int'(acb_irq), 0);
    chk("R5", "inverted line_sync idle level", int'(line_sync), 1);
    chk("R10", "frame_sync idle level", int'(frame_sync), 0);
    de_cnt = 0; eof_cnt = 0;
    repeat (200) begin
      @(negedge clk);
      if (data_en) de_cnt++;
      if (eof) eof_cnt++;
    end
    chk("R8", "data_en while never enabled", de_cnt, 0);
    chk("R8", "eof while never enabled", eof_cnt, 0);

    // ---- table of configurations
    for (int i = 0; i < NV; i++) begin
      load_vec(i);
      do_reset();
      scan_en = 1'b1;
      measure_frame();
      d  = (TAB[i][0] < 2) ? 2 : TAB[i][0];
      h  = (TAB[i][3] + 1) + (TAB[i][4] + 1) + 16 * (TAB[i][1] + 1) + (TAB[i][5] + 1);
      v  = (TAB[i][6] + 1) + (TAB[i][7] + 1) + (TAB[i][2] + 1) + (TAB[i][8] + 1);
      hf = (TAB[i][9] != 0) ? d - d / 2 : d / 2;
      chk("R7", $sformatf("vec%0d frame clocks", i), m_clk, TAB[i][14]);
      chk("R2", $sformatf("vec%0d line sync clocks", i), m_ls, d * (TAB[i][3] + 1) * v);
      chk("R3", $sformatf("vec%0d frame sync clocks", i), m_fs, d * h * (TAB[i][6] + 1));
      chk("R4", $sformatf("vec%0d data_en clocks", i), m_de,
          d * 16 * (TAB[i][1] + 1) * (TAB[i][2] + 1));
      chk("R1", $sformatf("vec%0d pclk high clocks", i), m_pc, hf * h * v);
      chk("R4", $sformatf("vec%0d max pix_x", i), m_maxx, 16 * (TAB[i][1] + 1) - 1);
      chk("R4", $sformatf("vec%0d max pix_y", i), m_maxy, TAB[i][2]);
      chk("R4", $sformatf("vec%0d first pix_x", i), m_fx, 0);
      chk("R4", $sformatf("vec%0d first pix_y", i), m_fy, 0);
      chk("R9", $sformatf("vec%0d ac_bias toggles", i), m_tog, v / (TAB[i][12] + 1));
      chk("R9", $sformatf("vec%0d acb_irq pulses", i), m_irq,
          (TAB[i][13] == 0) ? 0 : (v / (TAB[i][12] + 1)) / TAB[i][13]);
      chk("R8", $sformatf("vec%0d frame_done while enabled", i), int'(frame_done), 0);
    end

    // ---- sync edge selection, divisor 4
    load_vec(0);
    div_cfg = 8'd4;
    do_reset();
    sync_sel = 1'b1;
    sync_fall = 1'b0;
    scan_en = 1'b1;
    wait_ls_rise(pp, pn);
    chk("R6", "rising mode: pclk before sync edge", int'(pp), 0);
    chk("R6", "rising mode: pclk at sync edge", int'(pn), 1);
    sync_fall = 1'b1;
    repeat (20) @(negedge clk);
    wait_ls_rise(pp, pn);
    chk("R6", "falling mode: pclk before sync edge", int'(pp), 1);
    chk("R6", "falling mode: pclk at sync edge", int'(pn), 0);
    measure_frame();
    chk("R6", "falling mode frame clocks", m_clk, 4 * 23 * 8);
    chk("R6", "falling mode line sync clocks", m_ls, 4 * 2 * 8);

    // ---- stop at end of frame, sticky done, clear, restart
    load_vec(0);
    do_reset();
    scan_en = 1'b1;
    do @(negedge clk); while (eof !== 1'b1);
    de_cnt = 0;
    repeat (100) begin
      @(negedge clk);
      if (data_en) de_cnt++;
    end
    scan_en = 1'b0;
    h = 100;
    do begin
      @(negedge clk);
      h++;
      if (data_en) de_cnt++;
    end while (eof !== 1'b1);
    chk("R8", "stopping frame length", h, 368);
    chk("R8", "stopping frame data_en clocks", de_cnt, 2 * 16 * 4);
    chk("R8", "frame_done with final eof", int'(frame_done), 1);
    de_cnt = 0; eof_cnt = 0; ls_bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (data_en) de_cnt++;
      if (eof) eof_cnt++;
      if (line_sync != inv_lsync) ls_bad++;
    end
    chk("R8", "data_en after stop", de_cnt, 0);
    chk("R8", "eof after stop", eof_cnt, 0);
    chk("R8", "line_sync active after stop", ls_bad, 0);
    chk("R8", "frame_done held", int'(frame_done), 1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R8", "frame_done after clear", int'(frame_done), 0);
    scan_en = 1'b1;
    measure_frame();
    chk("R7", "frame clocks after restart", m_clk, 368);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule